// File: doc/BRIEF.md
# Multi-Wide Instruction Fetch Queue

This block sits between an instruction fetch stage and a two-wide decode stage. Each cycle the fetch side offers a group of zero to four instruction words, each with its address. The decode side receives the two oldest held entries and says how many it consumes. Words leave in exactly the order they were fetched. The store is a twelve-entry circular buffer.

A group is written only as a whole. When the free space is smaller than the offered group, the fetch-ready output drops and nothing is written, so fetch holds its group and offers it again later. Writing and consuming in the same cycle are both carried out. A flush, raised when a branch redirect or exception occurs, empties the buffer in one cycle. A flush overrides any write or consume in that cycle.

Top module: `instr_fetch_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `dq_valid` is 0, and `fe_ready` is 1 for any offered count from 0 to 4.
- R2: The offered count `fe_cnt` (legal values 0 to 4) says that lanes 0 to `fe_cnt-1` carry words. When `fe_ready` is 1 and no flush is raised, all of these lanes are written at the clock edge. Lane 0 is the oldest and lane `fe_cnt-1` the youngest. Lane k sits at bits [32k+31:32k] of `fe_word` and `fe_pc`.
- R3: `fe_ready` is 1 exactly when `fe_cnt` is not greater than the number of free entries. When it is 0, no lane of the group is written.
- R4: The queue never holds more than 12 entries. When it is full, any nonzero offered count sees `fe_ready` at 0.
- R5: `dq_valid` bit 0 is 1 when at least one entry is held, and bit 1 is 1 when at least two are held. Output lane 0 (bits [31:0] of `dq_word`/`dq_pc`) is the oldest entry and lane 1 (bits [63:32]) the next oldest.
- R6: `dq_take` (0 to 3) removes that many of the oldest entries at the clock edge. A value of 3 counts as 2, and the value is further limited to the number of entries held.
- R7: When a write and a consume fall in the same cycle, both take place. The occupancy changes by the number written minus the number removed.
- R8: When `flush` is 1, the queue is empty in the next cycle, whatever `fe_cnt` and `dq_take` were.
- R9: Across any mix of group sizes, consume counts and pointer wrap-around, words leave in the same order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held entries |
| fe_cnt | input | 3 | Number of valid lanes in the offered group (0 to 4) |
| fe_pc | input | 128 | Addresses of the offered lanes, lane 0 in the low bits |
| fe_word | input | 128 | Instruction words of the offered lanes |
| fe_ready | output | 1 | Offered group fits and is taken when not flushing |
| dq_take | input | 2 | Number of entries the decode stage consumes |
| dq_valid | output | 2 | Per-lane valid for the decode outputs |
| dq_pc | output | 64 | Addresses of the two oldest entries |
| dq_word | output | 64 | Instruction words of the two oldest entries |

## Verification
The bench first fills the queue with full groups of four. This shows that all lanes land in order and that a full queue refuses even a single word. It then offers groups that are too big for the space left, next to groups that just fit, which tells the boundary of the ready compare apart from an off-by-one. Writes paired with consumes of 1, 2 and the clamped value 3 check the net occupancy update. A single held entry checks that only lane 0 is shown. A flush raised together with a write and a consume checks its priority. A long mixed pattern of group sizes and consume counts drives both pointers around the buffer many times while a scoreboard checks the order of every word.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int unsigned IFQ_WORD_W = 32;

  typedef struct packed {
    logic [IFQ_WORD_W-1:0] pc;
    logic [IFQ_WORD_W-1:0] word;
  } ifq_entry_t;
endpackage

// File: rtl/ifq_ctrl.sv
module ifq_ctrl #(
  parameter int unsigned DEPTH     = 12,
  parameter int unsigned IN_LANES  = 4,
  parameter int unsigned OUT_LANES = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned FCW   = $clog2(IN_LANES + 1),
  localparam int unsigned TKW   = $clog2(OUT_LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [FCW-1:0]   fe_cnt,
  input  logic [TKW-1:0]   dq_take,
  output logic             fe_ready,
  output logic [FCW-1:0]   acc_cnt,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned SUM_W = PTR_W + 2;

  logic [CNT_W-1:0] count_q, free, acc, take_eff;
  logic [PTR_W-1:0] wr_q, rd_q, wr_nx, rd_nx;
  logic [SUM_W-1:0] wr_sum, rd_sum;

  // free space and the all-or-nothing group acceptance
  always_comb begin
    free     = CNT_W'(DEPTH) - count_q;
    fe_ready = CNT_W'(fe_cnt) <= free;
    acc      = (fe_ready && !flush) ? CNT_W'(fe_cnt) : '0;
  end

  // consume count: clamp to lane count, then to held entries
  always_comb begin
    take_eff = CNT_W'(dq_take);
    if (take_eff > CNT_W'(OUT_LANES)) take_eff = CNT_W'(OUT_LANES);
    if (take_eff > count_q) take_eff = count_q;
    if (flush) take_eff = '0;
  end

  // circular pointer advance, one subtract suffices as step <= DEPTH
  always_comb begin
    wr_sum = SUM_W'(wr_q) + SUM_W'(acc);
    rd_sum = SUM_W'(rd_q) + SUM_W'(take_eff);
    wr_nx  = PTR_W'((wr_sum >= SUM_W'(DEPTH)) ? wr_sum - SUM_W'(DEPTH) : wr_sum);
    rd_nx  = PTR_W'((rd_sum >= SUM_W'(DEPTH)) ? rd_sum - SUM_W'(DEPTH) : rd_sum);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      count_q <= count_q + acc - take_eff;
      wr_q    <= wr_nx;
      rd_q    <= rd_nx;
    end
  end

  assign acc_cnt = FCW'(acc);
  assign wr_ptr  = wr_q;
  assign rd_ptr  = rd_q;
  assign count   = count_q;

  // R4: occupancy bounded by capacity
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R3: a full queue refuses any nonempty group
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_W'(DEPTH) && fe_cnt != '0) |-> !fe_ready);

  // R7: no write and no consume leaves occupancy unchanged
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!flush && acc == '0 && take_eff == '0) |=> $stable(count_q));
endmodule

// File: rtl/ifq_store.sv
module ifq_store
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH     = 12,
  parameter int unsigned IN_LANES  = 4,
  parameter int unsigned OUT_LANES = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned FCW   = $clog2(IN_LANES + 1)
) (
  input  logic             clk,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [FCW-1:0]   acc_cnt,
  input  ifq_entry_t       wr_lane [IN_LANES],
  input  logic [PTR_W-1:0] rd_ptr,
  output ifq_entry_t       rd_lane [OUT_LANES]
);
  localparam int unsigned SUM_W = PTR_W + 2;

  ifq_entry_t       mem  [DEPTH];
  logic [SUM_W-1:0] slot [DEPTH];

  // distance of each entry from the write pointer, modulo DEPTH
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      slot[e] = (SUM_W'(e) >= SUM_W'(wr_ptr))
              ? SUM_W'(e) - SUM_W'(wr_ptr)
              : SUM_W'(e) + SUM_W'(DEPTH) - SUM_W'(wr_ptr);
    end
  end

  // entry at distance l takes lane l when l is inside the accepted group
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      for (int l = 0; l < IN_LANES; l++) begin
        if (SUM_W'(l) < SUM_W'(acc_cnt) && slot[e] == SUM_W'(l))
          mem[e] <= wr_lane[l];
      end
    end
  end

  for (genvar k = 0; k < OUT_LANES; k++) begin : g_rd
    logic [SUM_W-1:0] raw;
    logic [PTR_W-1:0] idx;
    assign raw = SUM_W'(rd_ptr) + SUM_W'(k);
    assign idx = PTR_W'((raw >= SUM_W'(DEPTH)) ? raw - SUM_W'(DEPTH) : raw);
    assign rd_lane[k] = mem[idx];
  end
endmodule

// File: rtl/instr_fetch_queue.sv
module instr_fetch_queue
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH     = 12,
  parameter int unsigned IN_LANES  = 4,
  parameter int unsigned OUT_LANES = 2,
  localparam int unsigned W     = IFQ_WORD_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned FCW   = $clog2(IN_LANES + 1),
  localparam int unsigned TKW   = $clog2(OUT_LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic [FCW-1:0]         fe_cnt,
  input  logic [IN_LANES*W-1:0]  fe_pc,
  input  logic [IN_LANES*W-1:0]  fe_word,
  output logic                   fe_ready,
  input  logic [TKW-1:0]         dq_take,
  output logic [OUT_LANES-1:0]   dq_valid,
  output logic [OUT_LANES*W-1:0] dq_pc,
  output logic [OUT_LANES*W-1:0] dq_word
);
  logic [FCW-1:0]   acc_cnt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  ifq_entry_t       in_lane  [IN_LANES];
  ifq_entry_t       out_lane [OUT_LANES];

  ifq_ctrl #(.DEPTH(DEPTH), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .fe_cnt(fe_cnt), .dq_take(dq_take),
    .fe_ready(fe_ready), .acc_cnt(acc_cnt), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count)
  );

  ifq_store #(.DEPTH(DEPTH), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES)) u_store (
    .clk(clk), .wr_ptr(wr_ptr), .acc_cnt(acc_cnt), .wr_lane(in_lane),
    .rd_ptr(rd_ptr), .rd_lane(out_lane)
  );

  for (genvar l = 0; l < IN_LANES; l++) begin : g_in
    assign in_lane[l].pc   = fe_pc[l*W +: W];
    assign in_lane[l].word = fe_word[l*W +: W];
  end

  for (genvar k = 0; k < OUT_LANES; k++) begin : g_out
    assign dq_valid[k]       = count > CNT_W'(k);
    assign dq_pc[k*W +: W]   = out_lane[k].pc;
    assign dq_word[k*W +: W] = out_lane[k].word;
    if (k > 0) begin : g_contig
      // R5: a younger lane is never valid without the older one
      p_valid_contig_r5: assert property (@(posedge clk) disable iff (rst)
        dq_valid[k] |-> dq_valid[k-1]);
    end
  end

  // R2: an empty queue accepts any legal group
  p_empty_accepts_r2: assert property (@(posedge clk) disable iff (rst)
    (dq_valid == '0 && fe_cnt <= FCW'(IN_LANES)) |-> fe_ready);

  // R8: flush leaves nothing visible on the next cycle
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> dq_valid == '0);
endmodule

// File: tb/sim_instr_fetch_queue.sv
module sim_instr_fetch_queue;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic [2:0]   fe_cnt = '0;
  logic [127:0] fe_pc = '0;
  logic [127:0] fe_word = '0;
  logic         fe_ready;
  logic [1:0]   dq_take = '0;
  logic [1:0]   dq_valid;
  logic [63:0]  dq_pc, dq_word;

  int total = 0;
  int bad = 0;
  int seq = 0;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;

  instr_fetch_queue u0 (
    .clk(clk), .rst(rst), .flush(flush), .fe_cnt(fe_cnt), .fe_pc(fe_pc),
    .fe_word(fe_word), .fe_ready(fe_ready), .dq_take(dq_take),
    .dq_valid(dq_valid), .dq_pc(dq_pc), .dq_word(dq_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // compare the decode outputs with the scoreboard head
  task automatic monitor(input string tag);
    int n;
    n = exp_q.size();
    chk(dq_valid[0] == (n >= 1), {tag, " R5 valid0"}, 64'(dq_valid), 64'(n));
    chk(dq_valid[1] == (n >= 2), {tag, " R5 valid1"}, 64'(dq_valid), 64'(n));
    for (int k = 0; k < 2; k++) begin
      if (k < n)
        chk({dq_pc[k*32 +: 32], dq_word[k*32 +: 32]} == exp_q[k],
            {tag, " R9 order"}, {dq_pc[k*32 +: 32], dq_word[k*32 +: 32]}, exp_q[k]);
    end
  endtask

  // driver: one cycle of stimulus, scoreboard updated at the edge
  task automatic step(input int n, input int take, input bit fl, input string tag);
    bit acc;
    int t;
    fe_cnt  = 3'(n);
    dq_take = 2'(take);
    flush   = fl;
    for (int l = 0; l < 4; l++) begin
      fe_pc[l*32 +: 32]   = 32'h1000 + 32'((seq + l) * 4);
      fe_word[l*32 +: 32] = 32'hA500_0000 + 32'(seq + l);
    end
    #1;
    acc = (n <= 12 - exp_q.size());
    chk(fe_ready == acc, {tag, " R3 ready"}, 64'(fe_ready), 64'(acc));
    monitor(tag);
    @(posedge clk);
    if (fl) begin
      exp_q.delete();
    end else begin
      t = (take > 2) ? 2 : take;
      if (t > exp_q.size()) t = exp_q.size();
      for (int i = 0; i < t; i++) void'(exp_q.pop_front());
      if (acc) begin
        for (int l = 0; l < n; l++)
          exp_q.push_back({32'h1000 + 32'((seq + l) * 4), 32'hA500_0000 + 32'(seq + l)});
        seq += n;
      end
    end
    @(negedge clk);
    fe_cnt = '0; dq_take = '0; flush = 1'b0;
    #1;
    monitor({tag, " post"});
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fe_cnt = 3'd4;
    #1;
    chk(dq_valid == 2'b00, "R1 empty after reset", 64'(dq_valid), 64'd0);
    chk(fe_ready == 1'b1, "R1 ready after reset", 64'(fe_ready), 64'd1);
    fe_cnt = '0;

    // R2: full groups fill in lane order; R4: capacity
    step(4, 0, 0, "R2 fill");
    step(4, 0, 0, "R2 fill");
    step(4, 0, 0, "R4 fill");
    chk(exp_q.size() == 12, "R4 model full", 64'(exp_q.size()), 64'd12);
    step(1, 0, 0, "R4 full refuse");
    step(4, 2, 0, "R3 too big");      // 12 held, refused, 2 leave
    step(3, 0, 0, "R3 too big 3");    // 10 held, free 2: refused
    step(2, 0, 0, "R3 just fits");    // fits exactly
    // R7: write and consume together
    step(0, 2, 0, "R6 take2");
    step(0, 3, 0, "R6 take3 clamp");
    step(2, 1, 0, "R7 net");
    step(4, 2, 0, "R7 net");
    // drain to one entry
    for (int i = 0; i < 12 && exp_q.size() > 1; i++) step(0, 1, 0, "R6 drain");
    step(0, 0, 0, "R5 single");
    step(0, 2, 0, "R6 take limited");
    step(0, 2, 0, "R6 take empty");
    // R8: flush beats simultaneous write and consume
    step(4, 0, 0, "R8 prep");
    step(3, 2, 1, "R8 flush");
    chk(dq_valid == 2'b00, "R8 empty after flush", 64'(dq_valid), 64'd0);
    step(2, 0, 0, "R8 after flush");
    // R9: long mixed pattern with wrap-around
    for (int i = 0; i < 300; i++)
      step((i * 7 + 3) % 5, (i * 3 + 1) % 4, (i % 97) == 96, "R9 mix");
    for (int i = 0; i < 8; i++) step(0, 2, 0, "R9 drain");
    chk(exp_q.size() == 0 && dq_valid == 2'b00, "R9 drained",
        64'(dq_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule